// File: doc/BRIEF.md
# Descriptor Queue Processing Engine

This block serves one endpoint queue. It walks a chain of 16-byte transfer descriptors that software has built in memory. Software gives a start address and a start command. The engine then reads each descriptor as four 32-bit words over a simple memory port and checks two things: that hardware owns the descriptor, and that the byte checksum is intact. It passes the buffer address and length to an abstract data mover. When the mover finishes, the engine writes the transferred length back, returns the descriptor to software, and follows the next pointer.

When the engine meets a descriptor that software still owns, or a descriptor that fails a check, it stops there and stays active. In this parked condition a resume command makes it fetch the same descriptor again, and a stop command brings it to rest. The engine reports whether it is active and which descriptor address it is working on. It raises single-cycle pulses for completion, checksum failure and zero-length transmit.

The controller has seven states:
- `ST_IDLE`: at rest. A start command moves it to `ST_FETCH`.
- `ST_FETCH`: issues a word read. Acceptance moves it to `ST_FWAIT`.
- `ST_FWAIT`: waits for the read data.
  - A word 0 without the own bit leads to `ST_PARK`.
  - The last word leads to `ST_CHECK`.
  - Any other word returns to `ST_FETCH`.
- `ST_CHECK`: judges the descriptor.
  - A bad checksum leads to `ST_PARK`.
  - A zero-length transmit leads to `ST_PARK`.
  - Bypass leads to `ST_WBACK`.
  - Otherwise it goes to `ST_MOVE`.
- `ST_MOVE`: holds the mover request. Mover completion leads to `ST_WBACK`.
- `ST_WBACK`: writes word 0 back. Once the write is accepted it goes to `ST_FETCH`, or to `ST_IDLE` if a stop is pending.
- `ST_PARK`: waits for software. Stop leads to `ST_IDLE`; resume leads to `ST_FETCH`.

Top module: `desc_queue_engine`

## Requirements
- R1: After reset `active` is 0, `cur_addr` is 0, `mem_valid` and `xfer_req` are 0, and no pulse output is high.
- R2: `cmd_start` while idle loads `cur_addr` from `start_addr` and makes `active` 1. `cmd_start` while active is ignored and leaves `cur_addr` unchanged.
- R3: A descriptor is read as four words at `cur_addr` + 0, 4, 8 and 12. The word layout is:
  - word0 = {length[31:16], checksum[15:8], flag[7:0]}
  - word1 = next pointer
  - word2 = buffer address
  - word3 = extension flags

  If bit 0 of the flag byte (own) is 0, the engine parks on that address. It then makes no transfer, no writeback and no pulse.
- R4: The checksum is good when the 8-bit sum of all 16 descriptor bytes equals 0xFF. A bad checksum gives one `csum_err_pulse` and parks the engine with `cur_addr` unchanged. The descriptor is not written.
- R5: A good owned descriptor raises `xfer_req`, with `xfer_addr` = word2 and `xfer_len` = length. The request holds until `xfer_done`. The engine then writes word0 back as {`xfer_actual`, checksum, flag with bit 0 cleared} and loads `cur_addr` from word1.
- R6: `done_pulse` fires once per written-back descriptor, and only when flag bit 7 (interrupt on completion) is set. The three pulse outputs are never high together.
- R7: When flag bit 2 (bypass) is set, the engine makes no transfer. It writes back a length of 0 with the own bit cleared, and then advances to the next pointer.
- R8: With `tx_mode` = 1, a non-bypass descriptor of length 0 gives one `len_err_pulse` and parks the engine with no transfer and no writeback. With `tx_mode` = 0, a zero-length descriptor is transferred normally.
- R9: `cmd_resume` while parked fetches the descriptor at `cur_addr` again. In any other state it has no effect.
- R10: `cmd_stop` while parked clears `active` on the following clock edge. Otherwise, the engine finishes the current descriptor's writeback and then goes idle without fetching the next one.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we` and `mem_addr` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| start_addr | input | AW | First descriptor address |
| tx_mode | input | 1 | 1 = transmit queue with zero-length error handling |
| active | output | 1 | Queue active status |
| cur_addr | output | AW | Address of the descriptor in process |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Data mover request |
| xfer_addr | output | 32 | Buffer address for the mover |
| xfer_len | output | 16 | Buffer length for the mover |
| xfer_done | input | 1 | Mover completion pulse |
| xfer_actual | input | 16 | Length actually moved |
| done_pulse | output | 1 | Completion pulse |
| csum_err_pulse | output | 1 | Checksum error pulse |
| len_err_pulse | output | 1 | Zero-length transmit error pulse |

## Verification
A wrong word index or descriptor capture would corrupt the summed bytes. It shows up within the same descriptor, as a checksum pulse on a descriptor that is good, or as the wrong `xfer_addr` or `xfer_len`. A wrong state transition shows up at the ports a few cycles later:
- a parked engine that still issues reads;
- a `cur_addr` that advances past a descriptor that failed;
- a stop that leaves `active` high;
- a next descriptor that is fetched after a stop.

The bench inspects the written-back word in memory after each run. A wrong writeback therefore shows up as a changed own bit or length at that address.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int DESC_WORDS = 4;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int LEN_W      = 16;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    // flag byte bit positions
    localparam int FLAG_OWN    = 0;
    localparam int FLAG_BYPASS = 2;
    localparam int FLAG_IOC    = 7;

    // word indices inside a descriptor
    localparam int W_HEAD = 0;
    localparam int W_NEXT = 1;
    localparam int W_BUF  = 2;

    localparam logic [BYTE_W-1:0] CSUM_GOOD = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FWAIT,
        ST_CHECK,
        ST_MOVE,
        ST_WBACK,
        ST_PARK
    } dq_state_t;
endpackage

// File: rtl/dq_csum.sv
module dq_csum
    import dq_pkg::*;
(
    input  logic [DESC_WORDS-1:0][WORD_W-1:0] words,
    output logic                               csum_ok
);
    localparam int BPW    = WORD_W / BYTE_W;
    localparam int NBYTES = DESC_WORDS * BPW;

    logic [NBYTES-1:0][BYTE_W-1:0] bytes_q;

    genvar gw, gb;
    generate
        for (gw = 0; gw < DESC_WORDS; gw++) begin : g_word
            for (gb = 0; gb < BPW; gb++) begin : g_byte
                assign bytes_q[gw*BPW+gb] = words[gw][gb*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    logic [BYTE_W-1:0] total;
    always_comb begin
        total = '0;
        for (int i = 0; i < NBYTES; i++) begin
            total = total + bytes_q[i];
        end
    end

    assign csum_ok = (total == CSUM_GOOD);
endmodule

// File: rtl/dq_desc_store.sv
module dq_desc_store
    import dq_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [WORD_W-1:0]                 word,
    output logic [DESC_WORDS-1:0][WORD_W-1:0] words
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words <= '0;
        end else if (load) begin
            words[idx] <= word;
        end
    end
endmodule

// File: rtl/desc_queue_engine.sv
module desc_queue_engine
    import dq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_resume,
    input  logic [AW-1:0]     start_addr,
    input  logic              tx_mode,
    output logic              active,
    output logic [AW-1:0]     cur_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    output logic [31:0]       xfer_addr,
    output logic [15:0]       xfer_len,
    input  logic              xfer_done,
    input  logic [15:0]       xfer_actual,
    output logic              done_pulse,
    output logic              csum_err_pulse,
    output logic              len_err_pulse
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);
    localparam int               WB_SHIFT = $clog2(WORD_W / BYTE_W);

    dq_state_t state, state_d;
    logic [IDX_W-1:0] widx;
    logic             stop_pend;
    logic [LEN_W-1:0] act_len;

    logic [DESC_WORDS-1:0][WORD_W-1:0] dwords;
    logic csum_ok;
    logic store_load;

    // decoded descriptor fields
    logic [BYTE_W-1:0] d_flag;
    logic [BYTE_W-1:0] d_csum;
    logic [LEN_W-1:0]  d_len;
    logic              d_bypass, d_ioc, d_zero_tx;

    assign d_flag    = dwords[W_HEAD][BYTE_W-1:0];
    assign d_csum    = dwords[W_HEAD][2*BYTE_W-1:BYTE_W];
    assign d_len     = dwords[W_HEAD][WORD_W-1:WORD_W-LEN_W];
    assign d_bypass  = d_flag[FLAG_BYPASS];
    assign d_ioc     = d_flag[FLAG_IOC];
    assign d_zero_tx = tx_mode && (d_len == '0);

    assign store_load = (state == ST_FWAIT) && mem_rvalid;

    dq_desc_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (store_load),
        .idx   (widx),
        .word  (mem_rdata),
        .words (dwords)
    );

    dq_csum u_csum (
        .words   (dwords),
        .csum_ok (csum_ok)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (cmd_start) state_d = ST_FETCH;
            ST_FETCH: if (mem_ready) state_d = ST_FWAIT;
            ST_FWAIT: begin
                if (mem_rvalid) begin
                    if (widx == '0 && !mem_rdata[FLAG_OWN]) state_d = ST_PARK;
                    else if (widx == LAST_IDX)              state_d = ST_CHECK;
                    else                                    state_d = ST_FETCH;
                end
            end
            ST_CHECK: begin
                if (!csum_ok)       state_d = ST_PARK;
                else if (d_bypass)  state_d = ST_WBACK;
                else if (d_zero_tx) state_d = ST_PARK;
                else                state_d = ST_MOVE;
            end
            ST_MOVE:  if (xfer_done) state_d = ST_WBACK;
            ST_WBACK: if (mem_ready) state_d = (stop_pend || cmd_stop) ? ST_IDLE : ST_FETCH;
            ST_PARK: begin
                if (stop_pend || cmd_stop) state_d = ST_IDLE;
                else if (cmd_resume)       state_d = ST_FETCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx           <= '0;
            stop_pend      <= 1'b0;
            cur_addr       <= '0;
            act_len        <= '0;
            done_pulse     <= 1'b0;
            csum_err_pulse <= 1'b0;
            len_err_pulse  <= 1'b0;
        end else begin
            if (state_d == ST_IDLE)
                stop_pend <= 1'b0;
            else if (cmd_stop && state != ST_IDLE)
                stop_pend <= 1'b1;

            if (state == ST_FWAIT && mem_rvalid && state_d == ST_FETCH)
                widx <= widx + 1'b1;
            else if (state_d == ST_FETCH && state != ST_FWAIT && state != ST_FETCH)
                widx <= '0;

            if (state == ST_IDLE && cmd_start)
                cur_addr <= start_addr;
            else if (state == ST_WBACK && mem_ready)
                cur_addr <= AW'(dwords[W_NEXT]);

            if (state == ST_CHECK && d_bypass)
                act_len <= '0;
            else if (state == ST_MOVE && xfer_done)
                act_len <= xfer_actual;

            done_pulse     <= (state == ST_WBACK) && mem_ready && d_ioc;
            csum_err_pulse <= (state == ST_CHECK) && !csum_ok;
            len_err_pulse  <= (state == ST_CHECK) && csum_ok && !d_bypass && d_zero_tx;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        active    = (state != ST_IDLE);
        mem_valid = (state == ST_FETCH) || (state == ST_WBACK);
        mem_we    = (state == ST_WBACK);
        mem_addr  = (state == ST_WBACK) ? cur_addr
                                        : cur_addr + (AW'(widx) << WB_SHIFT);
        mem_wdata = {act_len, d_csum, d_flag & ~(BYTE_W'(1) << FLAG_OWN)};
        xfer_req  = (state == ST_MOVE);
        xfer_addr = dwords[W_BUF];
        xfer_len  = d_len;
    end

    // ---------------- assertions ----------------
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_valid && !xfer_req && !done_pulse));

    assert_no_mem_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_valid && !xfer_req);

    assert_wb_clears_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> !mem_wdata[FLAG_OWN]);

    assert_xfer_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len));

    assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, csum_err_pulse, len_err_pulse}));

    assert_csum_err_holds_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err_pulse |-> $stable(cur_addr));

    assert_mem_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr));
endmodule

// File: tb/sim_desc_queue_engine.sv
module sim_desc_queue_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_stop = 0, cmd_resume = 0, tx_mode = 1;
    logic [AW-1:0] start_addr = '0;
    logic active, mem_valid, mem_ready, mem_we, mem_rvalid, xfer_req, xfer_done;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [31:0] mem_wdata, mem_rdata, xfer_addr;
    logic [15:0] xfer_len, xfer_actual;
    logic done_pulse, csum_err_pulse, len_err_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_queue_engine #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_resume(cmd_resume), .start_addr(start_addr), .tx_mode(tx_mode),
        .active(active), .cur_addr(cur_addr), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .xfer_actual(xfer_actual),
        .done_pulse(done_pulse), .csum_err_pulse(csum_err_pulse),
        .len_err_pulse(len_err_pulse)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [0:63];
    logic [31:0] cyc = 0;
    logic        tb_we = 0;
    logic [5:0]  tb_idx = 0;
    logic [31:0] tb_data = 0;
    assign mem_ready = (cyc[1:0] != 2'd3);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rvalid <= 1'b0;
        if (tb_we) mem[tb_idx] <= tb_data;
        if (mem_valid && mem_ready) begin
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[7:2]];
            end
        end
    end

    // ---------------- data mover model ----------------
    logic [2:0]  mv_cnt = 0;
    logic [31:0] last_xaddr = 0;
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (mv_cnt == 0 && xfer_req && !xfer_done) mv_cnt <= 3;
        else if (mv_cnt > 1) mv_cnt <= mv_cnt - 1;
        else if (mv_cnt == 1) begin
            xfer_done   <= 1'b1;
            xfer_actual <= (xfer_len > 16'd100) ? 16'd100 : xfer_len;
            last_xaddr  <= xfer_addr;
            mv_cnt      <= 0;
        end
    end

    // ---------------- observers ----------------
    int n_done = 0, n_cerr = 0, n_lerr = 0, n_moves = 0, n_proto = 0;
    logic        p_stall = 0;
    logic [31:0] p_addr = 0;
    always @(negedge clk) begin
        if (done_pulse) n_done++;
        if (csum_err_pulse) n_cerr++;
        if (len_err_pulse) n_lerr++;
        if (xfer_done) n_moves++;
        if (p_stall && (!mem_valid || mem_addr != p_addr)) n_proto++;
        p_stall = mem_valid && !mem_ready;
        p_addr  = mem_addr;
    end

    int checks = 0, errors = 0;
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] bsum(input logic [31:0] w);
        return w[7:0] + w[15:8] + w[23:16] + w[31:24];
    endfunction

    function automatic logic [7:0] mk_csum(input logic [7:0] f, input logic [15:0] l,
                                           input logic [31:0] n, b, e);
        logic [7:0] s;
        s = (f | 8'h01) + l[7:0] + l[15:8] + bsum(n) + bsum(b) + bsum(e);
        return 8'hFF - s;
    endfunction

    task automatic poke(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1; tb_idx = idx; tb_data = d;
        @(negedge clk);
        tb_we = 0;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [7:0] f,
                            input logic [15:0] l, input logic [31:0] nxt, input logic good);
        logic [31:0] b, e;
        logic [7:0]  c;
        b = 32'h1000_0000 + base;
        e = 32'h0000_0020;
        c = mk_csum(f, l, nxt, b, e) + (good ? 8'd0 : 8'd1);
        poke(base[7:2],     {l, c, f});
        poke(base[7:2] + 1, nxt);
        poke(base[7:2] + 2, b);
        poke(base[7:2] + 3, e);
    endtask

    task automatic cmd(input int which, input logic [31:0] a);
        @(negedge clk);
        start_addr = a;
        if (which == 0) cmd_start = 1;
        else if (which == 1) cmd_stop = 1;
        else cmd_resume = 1;
        @(negedge clk);
        cmd_start = 0; cmd_stop = 0; cmd_resume = 0;
    endtask

    task automatic clr_cnt();
        @(negedge clk);
        n_done = 0; n_cerr = 0; n_lerr = 0; n_moves = 0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [7:0]  flag;
        logic [15:0] len;
        logic        good;
        logic        tx;
        logic        e_done;
        logic        e_cerr;
        logic        e_lerr;
        logic        e_move;
        logic        e_adv;
        logic        e_wr;
        logic [15:0] e_wlen;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t [0:NV-1] VEC = '{
        '{8'h81, 16'd40,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd40},
        '{8'h01, 16'd40,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd40},
        '{8'h81, 16'd200, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd100},
        '{8'h81, 16'd40,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
        '{8'h81, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},
        '{8'h81, 16'd0,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd0},
        '{8'h85, 16'd0,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0},
        '{8'h80, 16'd40,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
        '{8'h05, 16'd30,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0}
    };

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 active", {31'b0, active}, 0);
        check("R1 cur_addr", cur_addr, 0);
        check("R1 mem_valid", {31'b0, mem_valid}, 0);
        check("R1 pulses", {29'b0, done_pulse, csum_err_pulse, len_err_pulse}, 0);
        rst_n = 1;
        idle_wait(2);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] w0;
            tx_mode = VEC[v].tx;
            poke(6'd32, 32'h0);
            put_desc(32'h40, VEC[v].flag, VEC[v].len, 32'h80, VEC[v].good);
            w0 = mem[16];
            clr_cnt();
            cmd(0, 32'h40);
            idle_wait(60);
            check($sformatf("R6 done v%0d", v), n_done, VEC[v].e_done);
            check($sformatf("R4 cerr v%0d", v), n_cerr, VEC[v].e_cerr);
            check($sformatf("R8 lerr v%0d", v), n_lerr, VEC[v].e_lerr);
            check($sformatf("R7 moves v%0d", v), n_moves, VEC[v].e_move);
            check($sformatf("R3 cur_addr v%0d", v), cur_addr, VEC[v].e_adv ? 32'h80 : 32'h40);
            check($sformatf("R5 writeback v%0d", v), mem[16],
                  VEC[v].e_wr ? {VEC[v].e_wlen, w0[15:8], w0[7:0] & 8'hFE} : w0);
            check($sformatf("R3 parked active v%0d", v), {31'b0, active}, 1);
            cmd(1, 0);
            idle_wait(1);
            check($sformatf("R10 stop parked v%0d", v), {31'b0, active}, 0);
        end

        // R2 / R9: park on unowned, start ignored, resume
        tx_mode = 1;
        poke(6'd32, 32'h0);
        put_desc(32'h40, 8'h80, 16'd20, 32'h80, 1);
        clr_cnt();
        cmd(0, 32'h40);
        idle_wait(30);
        check("R2 start loads", cur_addr, 32'h40);
        cmd(0, 32'h10);
        idle_wait(5);
        check("R2 start ignored while active", cur_addr, 32'h40);
        cmd(2, 0);
        idle_wait(30);
        check("R9 resume still unowned", n_moves, 0);
        check("R9 resume still unowned addr", cur_addr, 32'h40);
        put_desc(32'h40, 8'h81, 16'd20, 32'h80, 1);
        cmd(2, 0);
        idle_wait(40);
        check("R9 resume done", n_done, 1);
        check("R9 resume advanced", cur_addr, 32'h80);
        cmd(1, 0);
        idle_wait(2);
        clr_cnt();
        cmd(2, 0);
        idle_wait(10);
        check("R9 resume ignored when idle", {31'b0, active}, 0);
        check("R9 resume ignored when idle moves", n_moves, 0);

        // R5 chain of three
        put_desc(32'h40, 8'h81, 16'd10, 32'h50, 1);
        put_desc(32'h50, 8'h81, 16'd11, 32'h60, 1);
        put_desc(32'h60, 8'h81, 16'd12, 32'h80, 1);
        clr_cnt();
        cmd(0, 32'h40);
        idle_wait(120);
        check("R5 chain done", n_done, 3);
        check("R5 chain end addr", cur_addr, 32'h80);
        check("R5 chain xfer addr", last_xaddr, 32'h1000_0060);
        check("R5 chain last wb", mem[24][31:16], 16'd12);
        cmd(1, 0);
        idle_wait(2);

        // R10 stop during a descriptor
        put_desc(32'h40, 8'h81, 16'd10, 32'h50, 1);
        put_desc(32'h50, 8'h81, 16'd11, 32'h60, 1);
        clr_cnt();
        cmd(0, 32'h40);
        idle_wait(2);
        cmd(1, 0);
        idle_wait(60);
        check("R10 stop mid active", {31'b0, active}, 0);
        check("R10 stop mid done", n_done, 1);
        check("R10 stop mid addr", cur_addr, 32'h50);
        check("R10 next untouched", {31'b0, mem[20][0]}, 1);
        check("R11 handshake stable", n_proto, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule